// File: doc/BRIEF.md
# Cache Line Wrap Burst Address Generator

This block produces the byte address sequence of a burst read that fills one cache line. A burst begins at the critical byte the requester needs first. From there the address walks forward one byte per beat. In wrapped mode it stays inside an aligned window of 8, 16, 32 or 64 bytes, and it returns to the window base after the window's last byte. The cache therefore receives its whole line from one read command. In linear mode the address simply counts upward through the whole address space.

A three-bit wrap configuration word is written with a one-cycle load strobe while no burst is running. Bit 0 is the wrap-off bit. Bits 2:1 select the window length. The command that opens a burst can be an ordinary quad read or the dedicated wrap read. It arrives with a flag that tells the block whether the interface is in four-wire command mode, and the block decides from these inputs whether to wrap. A sticky flag reports when the burst has delivered a full window of bytes.

Top module: `wrap_burst_agen`

## Requirements
- R1: After reset the address output is 0 and both the busy and window-done outputs are 0. The configuration resets to wrap-off, so a burst started without any configuration load counts linearly.
- R2: In the cycle after a `start` pulse (with `stop` low), `addr_o` equals `start_addr`, `busy_o` is 1 and `line_done_o` is 0.
- R3: In linear mode each `advance` pulse during a burst adds 1 to the address, crossing window boundaries freely. The address rolls from all ones to 0.
- R4: In wrapped mode each `advance` increments only the low k address bits modulo 2^k and leaves the upper bits unchanged. `cfg_word[2:1]` selects k: 00 gives 3 (8 bytes), 01 gives 4, 10 gives 5 and 11 gives 6 (64 bytes).
- R5: In wrapped mode, `line_done_o` rises in the cycle after the advance that brings the beat count to the window length, when the address is back at the critical byte. It stays high while further advances keep wrapping, and it is never set in linear mode.
- R6: A quad read issued with `qpi_mode`=1 and `wrap_cmd`=0 runs linearly whatever the configuration says. With `qpi_mode`=0 and `wrap_cmd`=0 it wraps exactly when `cfg_word[0]` was loaded as 0.
- R7: A burst opened with `wrap_cmd`=1 always wraps, using the configured window length, in either interface mode and regardless of the wrap-off bit.
- R8: A `cfg_load` pulse is ignored while a burst is busy. A load taken while idle governs the next burst.
- R9: `stop` ends the burst in the next cycle (busy and done low) and takes priority over `start` and `advance`. While idle, `advance` leaves the address unchanged.
- R10: A `start` during a running burst restarts at the new critical address and clears the done flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | One-cycle strobe that writes `cfg_word` when idle |
| cfg_word | input | 3 | [0] wrap off, [2:1] window length select |
| start | input | 1 | Opens a burst at `start_addr` |
| start_addr | input | ADDR_W | Critical byte address |
| wrap_cmd | input | 1 | Burst comes from the dedicated wrap read command |
| qpi_mode | input | 1 | Interface is in four-wire command mode |
| advance | input | 1 | One byte delivered, step to the next address |
| stop | input | 1 | Ends the burst (chip select released) |
| addr_o | output | ADDR_W | Current byte address |
| busy_o | output | 1 | A burst is running |
| line_done_o | output | 1 | A full window has been delivered |

## Verification
The bench builds the block with ADDR_W set to 16. This narrower address lets a short linear burst from 0xFFFE show the rollover to zero, and it keeps the upper-bit hold of wrapped mode visible next to a high critical address. All four window lengths are swept with critical bytes placed mid-window. This exercises the full 64-beat window and the point where the done flag rises.

// File: rtl/wrap_burst_pkg.sv
`timescale 1ns/1ps
package wrap_burst_pkg;

    localparam int MIN_WIN_LOG = 3;
    localparam int NUM_LEN     = 4;
    localparam int LEN_SEL_W   = $clog2(NUM_LEN);
    localparam int MAX_WIN_LOG = MIN_WIN_LOG + NUM_LEN - 1;
    localparam int CNT_W       = MAX_WIN_LOG + 1;
    localparam int CFG_W       = LEN_SEL_W + 1;

    typedef struct packed {
        logic [LEN_SEL_W-1:0] len_sel;
        logic                 wrap_off;
    } wrap_cfg_t;

    localparam wrap_cfg_t CFG_RESET = '{len_sel: '0, wrap_off: 1'b1};

    function automatic logic [CNT_W-1:0] win_len(input logic [LEN_SEL_W-1:0] sel);
        return CNT_W'(1) << (MIN_WIN_LOG + int'(sel));
    endfunction

endpackage

// File: rtl/wrap_cfg_reg.sv
`timescale 1ns/1ps
module wrap_cfg_reg
    import wrap_burst_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      busy,
    input  wrap_cfg_t cfg_in,
    output wrap_cfg_t cfg_o
);

    wrap_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load && !busy) begin
            cfg_d = cfg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_q)); // R8

endmodule

// File: rtl/wrap_addr_step.sv
`timescale 1ns/1ps
module wrap_addr_step
    import wrap_burst_pkg::*;
#(
    parameter int ADDR_W = 24
)(
    input  logic [ADDR_W-1:0]    cur,
    input  logic                 wrap_en,
    input  logic [LEN_SEL_W-1:0] len_sel,
    output logic [ADDR_W-1:0]    nxt
);

    logic [ADDR_W-1:0] cand [NUM_LEN];
    logic [ADDR_W-1:0] lin_next;

    for (genvar g = 0; g < NUM_LEN; g++) begin : g_win
        localparam int LG = MIN_WIN_LOG + g;
        logic [LG-1:0] low_inc;
        assign low_inc = cur[LG-1:0] + LG'(1);
        assign cand[g] = {cur[ADDR_W-1:LG], low_inc};
    end

    assign lin_next = cur + ADDR_W'(1);

    always_comb begin
        if (wrap_en) begin
            nxt = cand[len_sel];
        end else begin
            nxt = lin_next;
        end
    end

endmodule

// File: rtl/wrap_beat_cnt.sv
`timescale 1ns/1ps
module wrap_beat_cnt
    import wrap_burst_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 step,
    input  logic                 wrap_en,
    input  logic [LEN_SEL_W-1:0] len_sel,
    output logic                 done_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (step && wrap_en && !st_q.done) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_d.cnt == win_len(len_sel)) begin
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= win_len(len_sel)); // R5

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done && !clear |=> st_q.done); // R5

endmodule

// File: rtl/wrap_burst_agen.sv
`timescale 1ns/1ps
module wrap_burst_agen
    import wrap_burst_pkg::*;
#(
    parameter int ADDR_W = 24
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [2:0]        cfg_word,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              wrap_cmd,
    input  logic              qpi_mode,
    input  logic              advance,
    input  logic              stop,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o,
    output logic              line_done_o
);

    typedef struct packed {
        logic [ADDR_W-1:0]    addr;
        logic                 busy;
        logic                 wrap;
        logic [LEN_SEL_W-1:0] len_sel;
    } burst_state_t;

    burst_state_t st_d, st_q;
    wrap_cfg_t    cfg_q;
    logic [ADDR_W-1:0] nxt_addr;
    logic         beat_step;
    logic         beat_clear;
    logic         done;

    wrap_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cfg_load),
        .busy   (st_q.busy),
        .cfg_in (wrap_cfg_t'(cfg_word)),
        .cfg_o  (cfg_q)
    );

    wrap_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur     (st_q.addr),
        .wrap_en (st_q.wrap),
        .len_sel (st_q.len_sel),
        .nxt     (nxt_addr)
    );

    assign beat_clear = stop | start;
    assign beat_step  = advance & st_q.busy & ~beat_clear;

    wrap_beat_cnt u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (beat_clear),
        .step    (beat_step),
        .wrap_en (st_q.wrap),
        .len_sel (st_q.len_sel),
        .done_o  (done)
    );

    always_comb begin
        st_d = st_q;
        if (stop) begin
            st_d.busy = 1'b0;
        end else if (start) begin
            st_d.busy    = 1'b1;
            st_d.addr    = start_addr;
            st_d.wrap    = wrap_cmd | (~qpi_mode & ~cfg_q.wrap_off);
            st_d.len_sel = cfg_q.len_sel;
        end else if (advance && st_q.busy) begin
            st_d.addr = nxt_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o      = st_q.addr;
    assign busy_o      = st_q.busy;
    assign line_done_o = done;

    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start && !stop |=> addr_o == $past(start_addr) && busy_o && !line_done_o); // R2

    AST_WRAP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && st_q.wrap && advance && !start && !stop
        |=> $stable(addr_o[ADDR_W-1:MAX_WIN_LOG])); // R4

    AST_LINEAR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.wrap |-> !line_done_o); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy && !start |=> $stable(addr_o)); // R9

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !busy_o && !line_done_o); // R9

endmodule

// File: tb/wrap_burst_agen_test.sv
`timescale 1ns/1ps
module wrap_burst_agen_test;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [2:0]    cfg_word = '0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          wrap_cmd = 1'b0;
    logic          qpi_mode = 1'b0;
    logic          advance = 1'b0;
    logic          stop = 1'b0;
    logic [AW-1:0] addr_o;
    logic          busy_o;
    logic          line_done_o;

    int errs = 0;
    int checks = 0;

    always #2 clk = ~clk;

    wrap_burst_agen #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .start(start), .start_addr(start_addr), .wrap_cmd(wrap_cmd),
        .qpi_mode(qpi_mode), .advance(advance), .stop(stop),
        .addr_o(addr_o), .busy_o(busy_o), .line_done_o(line_done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_load(input logic [2:0] w);
        cfg_word = w; cfg_load = 1'b1; cyc(); cfg_load = 1'b0;
    endtask

    task automatic do_start(input logic [AW-1:0] a, input logic wc, input logic q);
        start_addr = a; wrap_cmd = wc; qpi_mode = q; start = 1'b1;
        cyc(); start = 1'b0;
    endtask

    task automatic do_adv();
        advance = 1'b1; cyc(); advance = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1; cyc(); stop = 1'b0;
    endtask

    function automatic logic [AW-1:0] model_next(input logic [AW-1:0] a, input logic wrap, input int lg);
        int len, base, off;
        if (!wrap) return a + AW'(1);
        len  = 1 << lg;
        base = (int'(a) / len) * len;
        off  = ((int'(a) % len) + 1) % len;
        return AW'(base + off);
    endfunction

    task automatic t_reset();
        chk("R1 addr after reset", 32'(addr_o), 0);
        chk("R1 busy after reset", 32'(busy_o), 0);
        chk("R1 done after reset", 32'(line_done_o), 0);
        do_start(16'h00FE, 1'b0, 1'b0);
        chk("R2 start addr", 32'(addr_o), 32'h00FE);
        chk("R2 busy", 32'(busy_o), 1);
        do_adv(); chk("R1 default linear", 32'(addr_o), 32'h00FF);
        do_adv(); chk("R1 default linear cross", 32'(addr_o), 32'h0100);
        do_adv(); chk("R3 linear step", 32'(addr_o), 32'h0101);
        do_stop();
    endtask

    task automatic t_wrap(input logic [1:0] sel, input logic [AW-1:0] a);
        logic [AW-1:0] exp;
        int lg;
        int len;
        lg  = 3 + int'(sel);
        len = 1 << lg;
        do_load({sel, 1'b0});
        do_start(a, 1'b0, 1'b0);
        chk("R2 wrap start addr", 32'(addr_o), 32'(a));
        chk("R2 done low at start", 32'(line_done_o), 0);
        exp = a;
        for (int i = 1; i <= len; i++) begin
            do_adv();
            exp = model_next(exp, 1'b1, lg);
            chk("R4 wrap address", 32'(addr_o), 32'(exp));
            chk("R5 done timing", 32'(line_done_o), (i == len) ? 1 : 0);
        end
        chk("R5 back at critical byte", 32'(addr_o), 32'(a));
        for (int i = 0; i < 3; i++) begin
            do_adv();
            exp = model_next(exp, 1'b1, lg);
            chk("R4 keeps wrapping", 32'(addr_o), 32'(exp));
            chk("R5 done sticky", 32'(line_done_o), 1);
        end
        do_stop();
    endtask

    task automatic t_linear();
        do_load(3'b001);
        do_start(16'hFFFE, 1'b0, 1'b0);
        do_adv(); chk("R3 linear to top", 32'(addr_o), 32'hFFFF);
        do_adv(); chk("R3 linear rollover", 32'(addr_o), 32'h0000);
        for (int i = 0; i < 70; i++) do_adv();
        chk("R3 linear after 72", 32'(addr_o), 32'h0046);
        chk("R5 no done in linear", 32'(line_done_o), 0);
        do_stop();
    endtask

    task automatic t_modes();
        do_load(3'b000);
        do_start(16'h0037, 1'b0, 1'b1);
        do_adv(); chk("R6 quad read in qpi is linear", 32'(addr_o), 32'h0038);
        do_stop();
        do_start(16'h0037, 1'b0, 1'b0);
        do_adv(); chk("R6 quad read wraps outside qpi", 32'(addr_o), 32'h0030);
        do_stop();
        do_start(16'h0037, 1'b1, 1'b1);
        do_adv(); chk("R7 wrap command in qpi", 32'(addr_o), 32'h0030);
        do_stop();
        do_load(3'b011);
        do_start(16'h002F, 1'b1, 1'b0);
        do_adv(); chk("R7 wrap command ignores wrap-off", 32'(addr_o), 32'h0020);
        do_stop();
        do_start(16'h002F, 1'b0, 1'b0);
        do_adv(); chk("R6 wrap-off gives linear", 32'(addr_o), 32'h0030);
        do_stop();
    endtask

    task automatic t_cfg_lock();
        do_load(3'b000);
        do_start(16'h0047, 1'b0, 1'b0);
        do_load(3'b110);
        do_adv(); chk("R8 load ignored while busy", 32'(addr_o), 32'h0040);
        do_stop();
        do_start(16'h0047, 1'b0, 1'b0);
        do_adv(); chk("R8 earlier idle config kept", 32'(addr_o), 32'h0040);
        do_stop();
        do_load(3'b110);
        do_start(16'h0047, 1'b0, 1'b0);
        do_adv(); chk("R8 idle load applies 64B", 32'(addr_o), 32'h0048);
        do_stop();
    endtask

    task automatic t_stop_restart();
        do_load(3'b000);
        do_start(16'h0100, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) do_adv();
        chk("R5 done before stop", 32'(line_done_o), 1);
        stop = 1'b1; start = 1'b1; advance = 1'b1; start_addr = 16'h0200;
        cyc();
        stop = 1'b0; start = 1'b0; advance = 1'b0;
        chk("R9 stop busy low", 32'(busy_o), 0);
        chk("R9 stop done low", 32'(line_done_o), 0);
        chk("R9 stop wins, addr held", 32'(addr_o), 32'h0100);
        do_adv(); chk("R9 idle advance no effect", 32'(addr_o), 32'h0100);
        do_start(16'h0104, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) do_adv();
        chk("R10 done before restart", 32'(line_done_o), 1);
        do_start(16'h0305, 1'b0, 1'b0);
        chk("R10 restart addr", 32'(addr_o), 32'h0305);
        chk("R10 restart clears done", 32'(line_done_o), 0);
        chk("R10 still busy", 32'(busy_o), 1);
        do_adv(); chk("R10 restart steps", 32'(addr_o), 32'h0306);
        do_stop();
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_wrap(2'b00, 16'h1235);
        t_wrap(2'b01, 16'hABCD);
        t_wrap(2'b10, 16'h0071);
        t_wrap(2'b11, 16'hFFE9);
        t_linear();
        t_modes();
        t_cfg_lock();
        t_stop_restart();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule